// File: doc/BRIEF.md
# I2C Bus Status and Flag Register

This block holds the status byte of an I2C controller. It samples the raw SCL and SDA lines through a synchronizer and recognises start and stop conditions on the bus. From these it keeps a bus-busy bit. In master transmit mode it compares the levels the controller drives with the levels seen on the bus, and it records a lost arbitration. It also keeps the flags for an own-address match and a general-call match, the acknowledge bit and an interrupt-request flag.

The shift register, the baud generator and the address comparator sit outside this block. They report to it through single-cycle strobes: byte finished, own address hit, general call hit, data register written or read, and acknowledge sampled. The mode inputs select between master and slave, between transmit and receive, and between the two interrupt formats.

Software reads and writes one 8-bit status register. The sticky flags clear only through a read-then-write handshake or through a data register access. A write-only control bit combines with the busy bit to ask the bus controller for a start or a stop condition.

Top module: `i2c_stat_flags`

## Requirements
- R1: The busy bit (bit 7) becomes 1 after SDA falls while SCL is high (start), and 0 after SDA rises while SCL is high (stop). Both lines pass through the synchronizer first. The busy bit is not writable.
- R2: A register write with bit 5 at 0 pulses start_req for one cycle if bit 7 of the written data is 1, or stop_req if it is 0. A write with bit 5 at 1 pulses neither. Bit 5 always reads 1.
- R3: When master_mode=1 and transmit_mode=1, a rising SCL edge with sda_drv different from the synchronized bus SDA sets the arbitration-lost flag (bit 3). This check is inactive in any other mode.
- R4: When master_mode=1 and transmit_mode=1, a falling SCL edge while scl_drv is 1 sets the arbitration-lost flag.
- R5: The interrupt (bit 6), arbitration-lost (bit 3), address-match (bit 2) and general-call (bit 1) flags clear on a register write with 0 in their bit, but only if a register read has returned that flag as 1 since the flag was last cleared. Writing 1, or writing 0 without such a read, leaves the flag unchanged.
- R6: The address-match and general-call flags also clear on dr_write when transmit_mode=1, or on dr_read when transmit_mode=0. The other access, in the other mode, leaves them unchanged.
- R7: In slave receive mode (master_mode=0, transmit_mode=0), addr_hit or gcall_hit sets the address-match flag, and gcall_hit alone also sets the general-call flag. In any other mode both strobes are ignored.
- R8: In master mode, byte_done or a lost arbitration sets the interrupt flag.
- R9: In slave mode with fmt_sel=0, the interrupt flag is set by an address or general-call hit in slave receive mode. It is then set by each byte_done until the next start or stop condition. With fmt_sel=1, every byte_done sets it.
- R10: The acknowledge bit (bit 0) loads ack_rx on ack_sample when transmit_mode=1, and ignores ack_sample otherwise. A register write loads bit 0 of the data. ack_out follows the bit.
- R11: After reset the register reads 8'h30: bits 5 and 4 read 1, all other bits read 0, and no request is pulsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL bus level |
| sda_in | input | 1 | Raw SDA bus level |
| scl_drv | input | 1 | SCL level the controller drives (1 = released) |
| sda_drv | input | 1 | SDA level the controller drives (1 = released) |
| master_mode | input | 1 | 1 = master, 0 = slave |
| transmit_mode | input | 1 | 1 = transmit, 0 = receive |
| fmt_sel | input | 1 | Slave interrupt format select |
| byte_done | input | 1 | Strobe: a data transfer ended |
| addr_hit | input | 1 | Strobe: own slave address matched |
| gcall_hit | input | 1 | Strobe: general call address matched |
| dr_write | input | 1 | Strobe: data register written |
| dr_read | input | 1 | Strobe: data register read |
| ack_sample | input | 1 | Strobe: acknowledge slot sampled |
| ack_rx | input | 1 | Acknowledge level seen in the slot |
| reg_rd | input | 1 | Status register read strobe |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data |
| reg_rdata | output | 8 | Status register read data |
| bus_busy | output | 1 | Bus busy bit |
| irq_flag | output | 1 | Interrupt request flag |
| ack_out | output | 1 | Acknowledge level to drive in receive mode |
| start_req | output | 1 | One-cycle request for a start condition |
| stop_req | output | 1 | One-cycle request for a stop condition |

## Verification
The hardest state to reach is a repeated start while a slave session is open with fmt_sel at 0. Reaching it needs an address hit, then an SCL pulse that releases SDA while the bus stays busy, then a new start that must close the session. The stimulus lets SCL pulses move SDA while SCL is low, so random sequences of pulses, starts and stops produce repeated starts. The same pulses drive sda_drv and scl_drv at random in master transmit mode, which reaches both arbitration checks. Read and write operations are mixed in at random, so clears are tried both with and without the preceding read.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

   localparam int STAT_W   = 8;
   localparam int BIT_BUSY = 7;
   localparam int BIT_IRQ  = 6;
   localparam int BIT_SCP  = 5;
   localparam int BIT_RSV  = 4;
   localparam int BIT_AL   = 3;
   localparam int BIT_AAS  = 2;
   localparam int BIT_ADZ  = 1;
   localparam int BIT_ACK  = 0;

   typedef enum logic [1:0] {
      FLG_IRQ = 2'd0,
      FLG_AL  = 2'd1,
      FLG_AAS = 2'd2,
      FLG_ADZ = 2'd3
   } flag_idx_e;

   localparam int NUM_FLAGS = 4;

   typedef struct packed {
      logic rise;
      logic fall;
      logic start;
      logic stop;
   } bus_evt_t;

   function automatic int flag_pos(input int idx);
      case (idx)
         FLG_IRQ: return BIT_IRQ;
         FLG_AL:  return BIT_AL;
         FLG_AAS: return BIT_AAS;
         default: return BIT_ADZ;
      endcase
   endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
   import i2c_stat_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_raw,
   input  logic     sda_raw,
   output logic     sda_s,
   output bus_evt_t evt
);

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_prev;
   logic              sda_prev;
   logic              scl_s;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end
   end

   assign scl_s = scl_pipe[STAGES-1];
   assign sda_s = sda_pipe[STAGES-1];

   always_comb begin
      evt.rise  = scl_s & ~scl_prev;
      evt.fall  = ~scl_s & scl_prev;
      evt.start = scl_s & scl_prev & sda_prev & ~sda_s;
      evt.stop  = scl_s & scl_prev & ~sda_prev & sda_s;
   end

endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor #(
   parameter bit FALL_CHECK = 1'b1
) (
   input  logic en,
   input  logic scl_rise,
   input  logic scl_fall,
   input  logic sda_s,
   input  logic sda_drv,
   input  logic scl_drv,
   output logic lost
);

   logic rise_loss;
   logic fall_loss;

   assign rise_loss = scl_rise & (sda_drv ^ sda_s);

   generate
      if (FALL_CHECK) begin : g_fall_on
         assign fall_loss = scl_fall & scl_drv;
      end else begin : g_fall_off
         logic fall_inputs_unused;
         assign fall_inputs_unused = scl_fall ^ scl_drv;
         assign fall_loss = 1'b0;
      end
   endgenerate

   assign lost = en & (rise_loss | fall_loss);

endmodule

// File: rtl/i2c_sticky_flag.sv
module i2c_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic hw_clr_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic q_o
);

   logic armed;
   logic sw_clr;

   assign sw_clr = wr_i & ~wbit_i & armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o   <= 1'b0;
         armed <= 1'b0;
      end else if (set_i) begin
         q_o <= 1'b1;
      end else if (hw_clr_i || sw_clr) begin
         q_o   <= 1'b0;
         armed <= 1'b0;
      end else if (rd_i) begin
         armed <= q_o;
      end
   end

endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
   import i2c_stat_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter bit ARB_FALL_CHECK = 1'b1,
   parameter int REG_W          = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   input  logic             scl_drv,
   input  logic             sda_drv,
   input  logic             master_mode,
   input  logic             transmit_mode,
   input  logic             fmt_sel,
   input  logic             byte_done,
   input  logic             addr_hit,
   input  logic             gcall_hit,
   input  logic             dr_write,
   input  logic             dr_read,
   input  logic             ack_sample,
   input  logic             ack_rx,
   input  logic             reg_rd,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             bus_busy,
   output logic             irq_flag,
   output logic             ack_out,
   output logic             start_req,
   output logic             stop_req
);

   generate
      if (REG_W != STAT_W) begin : g_bad_width
         $error("i2c_stat_flags: REG_W must equal the status byte width");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("i2c_stat_flags: SYNC_STAGES must be at least 2");
      end
   endgenerate

   bus_evt_t             evt;
   logic                 sda_s;
   logic                 arb_lost;
   logic                 mstr_tx;
   logic                 slv_rx;
   logic                 addr_evt;
   logic                 irq_set;
   logic                 dr_clr;
   logic                 busy_q;
   logic                 session_q;
   logic                 ack_q;
   logic                 ctrl_wr;
   logic [NUM_FLAGS-1:0] flag_set;
   logic [NUM_FLAGS-1:0] flag_clr;
   logic [NUM_FLAGS-1:0] flag_q;
   logic                 rsv_wr_unused;

   assign rsv_wr_unused = reg_wdata[BIT_RSV];

   i2c_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_raw (scl_in),
      .sda_raw (sda_in),
      .sda_s   (sda_s),
      .evt     (evt)
   );

   assign mstr_tx = master_mode & transmit_mode;
   assign slv_rx  = ~master_mode & ~transmit_mode;

   i2c_arb_monitor #(
      .FALL_CHECK (ARB_FALL_CHECK)
   ) u_arb (
      .en       (mstr_tx),
      .scl_rise (evt.rise),
      .scl_fall (evt.fall),
      .sda_s    (sda_s),
      .sda_drv  (sda_drv),
      .scl_drv  (scl_drv),
      .lost     (arb_lost)
   );

   // Bus occupancy from detected conditions
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (evt.start) begin
         busy_q <= 1'b1;
      end else if (evt.stop) begin
         busy_q <= 1'b0;
      end
   end

   // Slave session: opened by an address hit, closed by any start or stop
   assign addr_evt = slv_rx & (addr_hit | gcall_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         session_q <= 1'b0;
      end else if (addr_evt) begin
         session_q <= 1'b1;
      end else if (evt.start || evt.stop) begin
         session_q <= 1'b0;
      end
   end

   always_comb begin
      if (master_mode) begin
         irq_set = byte_done | arb_lost;
      end else if (fmt_sel) begin
         irq_set = byte_done;
      end else begin
         irq_set = addr_evt | (byte_done & session_q);
      end
   end

   assign dr_clr = (dr_write & transmit_mode) | (dr_read & ~transmit_mode);

   always_comb begin
      flag_set          = '0;
      flag_clr          = '0;
      flag_set[FLG_IRQ] = irq_set;
      flag_set[FLG_AL]  = arb_lost;
      flag_set[FLG_AAS] = addr_evt;
      flag_set[FLG_ADZ] = slv_rx & gcall_hit;
      flag_clr[FLG_AAS] = dr_clr;
      flag_clr[FLG_ADZ] = dr_clr;
   end

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      i2c_sticky_flag u_flag (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_i    (flag_set[g]),
         .hw_clr_i (flag_clr[g]),
         .rd_i     (reg_rd),
         .wr_i     (reg_wr),
         .wbit_i   (reg_wdata[flag_pos(g)]),
         .q_o      (flag_q[g])
      );
   end

   // Acknowledge bit: sampled response in transmit, software level otherwise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
      end else if (transmit_mode && ack_sample) begin
         ack_q <= ack_rx;
      end else if (reg_wr) begin
         ack_q <= reg_wdata[BIT_ACK];
      end
   end

   // Start or stop request on a write with the control bit at zero
   assign ctrl_wr = reg_wr & ~reg_wdata[BIT_SCP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_req <= 1'b0;
         stop_req  <= 1'b0;
      end else begin
         start_req <= ctrl_wr & reg_wdata[BIT_BUSY];
         stop_req  <= ctrl_wr & ~reg_wdata[BIT_BUSY];
      end
   end

   always_comb begin
      reg_rdata           = '0;
      reg_rdata[BIT_BUSY] = busy_q;
      reg_rdata[BIT_IRQ]  = flag_q[FLG_IRQ];
      reg_rdata[BIT_SCP]  = 1'b1;
      reg_rdata[BIT_RSV]  = 1'b1;
      reg_rdata[BIT_AL]   = flag_q[FLG_AL];
      reg_rdata[BIT_AAS]  = flag_q[FLG_AAS];
      reg_rdata[BIT_ADZ]  = flag_q[FLG_ADZ];
      reg_rdata[BIT_ACK]  = ack_q;
   end

   assign bus_busy = busy_q;
   assign irq_flag = flag_q[FLG_IRQ];
   assign ack_out  = ack_q;

endmodule

// File: rtl/i2c_stat_flags_chk.sv
module i2c_stat_flags_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       master_mode,
   input logic       transmit_mode,
   input logic       dr_write,
   input logic       dr_read,
   input logic       reg_wr,
   input logic [7:0] reg_wdata,
   input logic [7:0] reg_rdata,
   input logic       start_req,
   input logic       stop_req
);

   // R5
   irq_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_rdata[6]) |-> $past(reg_wr && !reg_wdata[6]));

   // R3
   al_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[3]) |-> $past(master_mode && transmit_mode));

   // R6
   aas_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_rdata[2]) |-> $past((reg_wr && !reg_wdata[2]) ||
                                    (dr_write && transmit_mode) ||
                                    (dr_read && !transmit_mode)));

   // R7
   gcall_with_aas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[1]) |-> reg_rdata[2]);

   // R2
   start_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_req) |-> $past(reg_wr && !reg_wdata[5] && reg_wdata[7]));

   // R2
   stop_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_req) |-> $past(reg_wr && !reg_wdata[5] && !reg_wdata[7]));

endmodule

bind i2c_stat_flags i2c_stat_flags_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .master_mode   (master_mode),
   .transmit_mode (transmit_mode),
   .dr_write      (dr_write),
   .dr_read       (dr_read),
   .reg_wr        (reg_wr),
   .reg_wdata     (reg_wdata),
   .reg_rdata     (reg_rdata),
   .start_req     (start_req),
   .stop_req      (stop_req)
);

// File: tb/i2c_stat_flags_bench.sv
`timescale 1ns/1ps
module i2c_stat_flags_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_in = 1'b1, sda_in = 1'b1, scl_drv = 1'b1, sda_drv = 1'b1;
   logic       master_mode = 1'b0, transmit_mode = 1'b0, fmt_sel = 1'b0;
   logic       byte_done = 1'b0, addr_hit = 1'b0, gcall_hit = 1'b0;
   logic       dr_write = 1'b0, dr_read = 1'b0, ack_sample = 1'b0, ack_rx = 1'b0;
   logic       reg_rd = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       bus_busy, irq_flag, ack_out, start_req, stop_req;

   int nchecks = 0;
   int nerrors = 0;
   bit finished = 1'b0;

   bit m_busy, m_irq, m_al, m_aas, m_adz, m_ack, m_sess;
   bit a_irq, a_al, a_aas, a_adz;

   always #4 clk = ~clk;

   i2c_stat_flags u_i2c_stat_flags (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_drv(scl_drv), .sda_drv(sda_drv), .master_mode(master_mode),
      .transmit_mode(transmit_mode), .fmt_sel(fmt_sel), .byte_done(byte_done),
      .addr_hit(addr_hit), .gcall_hit(gcall_hit), .dr_write(dr_write),
      .dr_read(dr_read), .ack_sample(ack_sample), .ack_rx(ack_rx),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .bus_busy(bus_busy), .irq_flag(irq_flag),
      .ack_out(ack_out), .start_req(start_req), .stop_req(stop_req)
   );

   function automatic logic [7:0] exp_byte();
      return {m_busy, m_irq, 2'b11, m_al, m_aas, m_adz, m_ack};
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      nchecks++;
      if (act !== exp) begin
         nerrors++;
         $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   task automatic read_chk(input string tag);
      @(negedge clk);
      reg_rd = 1'b1;
      #1;
      check(tag, "status", reg_rdata, exp_byte());
      check(tag, "busy pin", {7'd0, bus_busy}, {7'd0, m_busy});
      check(tag, "irq pin", {7'd0, irq_flag}, {7'd0, m_irq});
      check(tag, "ack pin", {7'd0, ack_out}, {7'd0, m_ack});
      a_irq = m_irq; a_al = m_al; a_aas = m_aas; a_adz = m_adz;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic write_reg(input string tag, input logic [7:0] w);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = w;
      @(negedge clk);
      reg_wr = 1'b0;
      #1;
      check(tag, "start_req", {7'd0, start_req}, {7'd0, !w[5] && w[7]});
      check(tag, "stop_req", {7'd0, stop_req}, {7'd0, !w[5] && !w[7]});
      if (!w[6] && a_irq && m_irq) begin m_irq = 0; a_irq = 0; end
      if (!w[3] && a_al && m_al) begin m_al = 0; a_al = 0; end
      if (!w[2] && a_aas && m_aas) begin m_aas = 0; a_aas = 0; end
      if (!w[1] && a_adz && m_adz) begin m_adz = 0; a_adz = 0; end
      m_ack = w[0];
   endtask

   task automatic set_mode(input bit mm, input bit tx, input bit fs);
      @(negedge clk);
      master_mode = mm; transmit_mode = tx; fmt_sel = fs;
   endtask

   // 0 addr_hit, 1 gcall_hit, 2 byte_done, 3 dr_write, 4 dr_read
   task automatic pulse_ev(input int which);
      bit srx;
      srx = !master_mode && !transmit_mode;
      @(negedge clk);
      case (which)
         0: addr_hit = 1'b1;
         1: gcall_hit = 1'b1;
         2: byte_done = 1'b1;
         3: dr_write = 1'b1;
         default: dr_read = 1'b1;
      endcase
      @(negedge clk);
      {addr_hit, gcall_hit, byte_done, dr_write, dr_read} = '0;
      case (which)
         0, 1: if (srx) begin
            m_aas = 1; m_sess = 1;
            if (which == 1) m_adz = 1;
            if (!fmt_sel) m_irq = 1;
         end
         2: begin
            if (master_mode) m_irq = 1;
            else if (fmt_sel) m_irq = 1;
            else if (m_sess) m_irq = 1;
         end
         3: if (transmit_mode) begin m_aas = 0; m_adz = 0; a_aas = 0; a_adz = 0; end
         default: if (!transmit_mode) begin m_aas = 0; m_adz = 0; a_aas = 0; a_adz = 0; end
      endcase
   endtask

   task automatic ack_op(input bit v);
      @(negedge clk);
      ack_sample = 1'b1; ack_rx = v;
      @(negedge clk);
      ack_sample = 1'b0;
      if (transmit_mode) m_ack = v;
   endtask

   task automatic bus_cond();
      @(negedge clk);
      sda_in = ~sda_in;
      sda_drv = sda_in;
      repeat (6) @(negedge clk);
      m_busy = !sda_in;
      m_sess = 0;
   endtask

   task automatic scl_pulse(input bit new_sda, input bit mis, input bit fall_hi);
      bit lost;
      lost = master_mode && transmit_mode && (mis || fall_hi);
      @(negedge clk);
      scl_in = 1'b0; scl_drv = fall_hi;
      repeat (6) @(negedge clk);
      scl_drv = 1'b0; sda_in = new_sda;
      repeat (6) @(negedge clk);
      sda_drv = mis ? !new_sda : new_sda;
      scl_in = 1'b1;
      repeat (6) @(negedge clk);
      sda_drv = new_sda; scl_drv = 1'b1;
      if (lost) begin m_al = 1; m_irq = 1; end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nerrors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset value
      #1;
      check("R11", "start_req", {7'd0, start_req}, 8'd0);
      check("R11", "stop_req", {7'd0, stop_req}, 8'd0);
      read_chk("R11");

      // R1 start and stop tracking
      bus_cond(); read_chk("R1");
      bus_cond(); read_chk("R1");

      // R2 requests
      write_reg("R2", 8'h80);
      write_reg("R2", 8'h00);
      write_reg("R2", 8'hA0);
      read_chk("R2");

      // R3 rising-edge mismatch in master transmit
      set_mode(1, 1, 0);
      bus_cond();
      scl_pulse(0, 1, 0); read_chk("R3");
      write_reg("R5", 8'h20); read_chk("R5");
      // R4 falling edge with internal SCL high
      scl_pulse(0, 0, 1); read_chk("R4");
      write_reg("R4", 8'h20); read_chk("R4");
      // R5 write 0 without prior read does nothing; writing 1 does nothing
      scl_pulse(0, 1, 0);
      write_reg("R5", 8'h20); read_chk("R5");
      write_reg("R5", 8'hFF); read_chk("R5");
      write_reg("R5", 8'h20); read_chk("R5");
      // R3 inactive outside master transmit
      set_mode(1, 0, 0);
      scl_pulse(0, 1, 1); read_chk("R3");

      // R7 address hits in slave receive
      set_mode(0, 0, 0);
      pulse_ev(0); read_chk("R7");
      pulse_ev(1); read_chk("R7");
      // R6 data register clears
      pulse_ev(4); read_chk("R6");
      pulse_ev(1);
      set_mode(0, 1, 0);
      pulse_ev(4); read_chk("R6");
      pulse_ev(3); read_chk("R6");
      // R7 hits ignored in slave transmit
      write_reg("R7", 8'h20);
      pulse_ev(1); read_chk("R7");

      // R9 session rules with fmt_sel=0, then fmt_sel=1
      set_mode(0, 0, 0);
      pulse_ev(0); read_chk("R9"); write_reg("R9", 8'h20);
      pulse_ev(2); read_chk("R9"); write_reg("R9", 8'h20);
      scl_pulse(1, 0, 0); bus_cond();
      pulse_ev(2); read_chk("R9");
      set_mode(0, 0, 1);
      pulse_ev(2); read_chk("R9"); write_reg("R9", 8'h20);

      // R8 master end of transfer
      set_mode(1, 0, 0);
      pulse_ev(2); read_chk("R8"); write_reg("R8", 8'h20);

      // R10 acknowledge handling
      set_mode(1, 1, 0);
      ack_op(1); read_chk("R10");
      set_mode(0, 0, 0);
      ack_op(0); read_chk("R10");
      write_reg("R10", 8'h20); read_chk("R10");

      // Random mix
      for (int i = 0; i < 500; i++) begin
         int op;
         op = $urandom_range(0, 11);
         case (op)
            0: begin
               set_mode($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
               read_chk("R9");
            end
            1: begin bus_cond(); read_chk("R1"); end
            2: begin
               scl_pulse($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
               read_chk("R3");
            end
            3: begin pulse_ev(0); read_chk("R7"); end
            4: begin pulse_ev(1); read_chk("R7"); end
            5: begin pulse_ev(2); read_chk("R8"); end
            6: begin pulse_ev(3); read_chk("R6"); end
            7: begin pulse_ev(4); read_chk("R6"); end
            8: begin ack_op($urandom_range(0, 1)); read_chk("R10"); end
            9, 10: begin
               logic [7:0] w;
               w = 8'($urandom);
               write_reg("R5", w);
               if ($urandom_range(0, 1) == 1) read_chk("R5");
            end
            default: read_chk("R5");
         endcase
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
   end

endmodule